// File: doc/BRIEF.md
# Three-Channel Count Timer

The block holds three independent counters behind a plain word-wide register port. Each channel has a counter that software can read or load at any time, a reload value, and two compare values. A shared control word turns each channel on, chooses its count source (every bus clock, or each rising edge of a synchronized external clock pin), and decides whether wrap events are reported. One global bit sets the count direction of all three channels.

Compare hits and wraps set sticky status bits. Software clears them by writing ones to the status word. A mask word then decides which status bits can drive the single interrupt line. A typical use is to run one channel free as a time base while a second one raises periodic or one-shot events through its compare registers.

Top module: `tt_top`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is low.
- R2: Word addresses are decoded on `bus_addr[5:2]`. Channel n (0..2) has its bank at byte offset 16*n: counter at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC. These are full-width read/write while the channel is off. Control is at 0x30 (10 bits). Status is at 0x34 (9 bits). Mask is at 0x38 (9 bits). 0x3C reads 0 and ignores writes.
- R3: Control bit 3n turns channel n on. When control bit 9 is 0, an on channel decrements on each tick. On the tick after it reads 0 it loads the reload value.
- R4: When control bit 9 is 1, channels increment. On the tick after all ones the channel loads the reload value.
- R5: A tick whose new counter value equals compare A sets status bit 3n. If it equals compare B, it sets status bit 3n+1. A reload counts as a new value.
- R6: A reload sets status bit 3n+2 only when control bit 3n+2 is 1.
- R7: A channel whose bit 3n is 0 holds its count and sets no status bits.
- R8: Status bits stay set until software writes 1 to that bit at 0x34. Zero bits in the write leave status unchanged.
- R9: `irq_out` is high exactly when some status bit is set whose mask bit is 0.
- R10: When control bit 3n+1 is 1, channel n advances once per rising edge of `ext_clk` after a two-stage synchronizer. A level held high gives one count, and a steady input gives none.
- R11: A bus write to the counter takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_clk | input | 1 | Asynchronous external count source |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 32-bit counters and a two-stage synchronizer. The 32-bit wrap is reached without long runs by preloading the counter a few counts below all ones. The two-stage synchronizer keeps the delay from an external edge to a count short. This lets a few-cycle pulse prove both the single count per edge and the absence of counts on a steady level.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {SLOT_CNT, SLOT_RLD, SLOT_CMPA, SLOT_CMPB} tt_slot_e;
  typedef enum logic [1:0] {G_CTRL, G_STAT, G_MASK, G_NONE} tt_glob_e;
  localparam logic [1:0] GLOBAL_BANK = 2'd3;

  function automatic int en_bit(input int n);  return 3 * n;     endfunction
  function automatic int sel_bit(input int n); return 3 * n + 1; endfunction
  function automatic int ie_bit(input int n);  return 3 * n + 2; endfunction
endpackage

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tt_channel.sv
module tt_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         up,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic         wr_cmpa,
  input  logic         wr_cmpb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic [W-1:0] cmpa,
  output logic [W-1:0] cmpb,
  output logic         ovf_evt,
  output logic         cmpa_evt,
  output logic         cmpb_evt
);
  // returns {wrapped, next_value}
  function automatic logic [W:0] step(input logic [W-1:0] cur, input logic dir_up,
                                      input logic [W-1:0] reload);
    if (dir_up) begin
      if (cur == {W{1'b1}}) return {1'b1, reload};
      return {1'b0, cur + 1'b1};
    end
    if (cur == '0) return {1'b1, reload};
    return {1'b0, cur - 1'b1};
  endfunction

  logic [W:0] stepped;
  logic       adv;

  assign stepped  = step(cnt, up, rld);
  assign adv      = tick & ~wr_cnt;
  assign ovf_evt  = adv & stepped[W];
  assign cmpa_evt = adv & (stepped[W-1:0] == cmpa);
  assign cmpb_evt = adv & (stepped[W-1:0] == cmpb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rld  <= '0;
      cmpa <= '0;
      cmpb <= '0;
    end else begin
      if (wr_cnt)   cnt <= wdata;
      else if (adv) cnt <= stepped[W-1:0];
      if (wr_rld)  rld  <= wdata;
      if (wr_cmpa) cmpa <= wdata;
      if (wr_cmpb) cmpb <= wdata;
    end
  end
endmodule

// File: rtl/tt_top.sv
module tt_top #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  output logic              irq_out
);
  import tt_pkg::*;

  localparam int N_TMR  = 3;
  localparam int ST_W   = 3 * N_TMR;
  localparam int CTRL_W = ST_W + 1;
  localparam int UP_BIT = ST_W;

  logic [1:0] bank;
  logic [1:0] slot;
  assign bank = bus_addr[5:4];
  assign slot = bus_addr[3:2];

  logic [CTRL_W-1:0]             ctrl_q;
  logic [ST_W-1:0]               st_q, st_set, st_clr;
  logic [ST_W-1:0]               mask_q;
  logic [N_TMR-1:0][DATA_W-1:0]  cnt_q, rld_q, cmpa_q, cmpb_q;
  logic [N_TMR-1:0]              tick, cnt_wr, ovf_evt, cmpa_evt, cmpb_evt;
  logic                          ext_rise;
  logic                          glob_wr;

  tt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise)
  );

  for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
    logic hit;
    assign hit       = bus_we && (bank == 2'(n));
    assign cnt_wr[n] = hit && (slot == SLOT_CNT);
    assign tick[n]   = ctrl_q[en_bit(n)] & (ctrl_q[sel_bit(n)] ? ext_rise : 1'b1);

    tt_channel #(.W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick[n]), .up(ctrl_q[UP_BIT]),
      .wr_cnt(cnt_wr[n]), .wr_rld(hit && (slot == SLOT_RLD)),
      .wr_cmpa(hit && (slot == SLOT_CMPA)), .wr_cmpb(hit && (slot == SLOT_CMPB)),
      .wdata(bus_wdata), .cnt(cnt_q[n]), .rld(rld_q[n]),
      .cmpa(cmpa_q[n]), .cmpb(cmpb_q[n]),
      .ovf_evt(ovf_evt[n]), .cmpa_evt(cmpa_evt[n]), .cmpb_evt(cmpb_evt[n])
    );

    assign st_set[en_bit(n)]  = cmpa_evt[n];
    assign st_set[sel_bit(n)] = cmpb_evt[n];
    assign st_set[ie_bit(n)]  = ovf_evt[n] & ctrl_q[ie_bit(n)];
  end

  assign glob_wr = bus_we && (bank == GLOBAL_BANK);
  assign st_clr  = (glob_wr && slot == G_STAT) ? bus_wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      st_q   <= '0;
    end else begin
      if (glob_wr && slot == G_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (glob_wr && slot == G_MASK) mask_q <= bus_wdata[ST_W-1:0];
      st_q <= (st_q & ~st_clr) | st_set;
    end
  end

  assign irq_out = |(st_q & ~mask_q);

  always_comb begin
    bus_rdata = '0;
    if (bank != GLOBAL_BANK) begin
      case (slot)
        SLOT_CNT:  bus_rdata = cnt_q[bank];
        SLOT_RLD:  bus_rdata = rld_q[bank];
        SLOT_CMPA: bus_rdata = cmpa_q[bank];
        default:   bus_rdata = cmpb_q[bank];
      endcase
    end else begin
      case (slot)
        G_CTRL:  bus_rdata = DATA_W'(ctrl_q);
        G_STAT:  bus_rdata = DATA_W'(st_q);
        G_MASK:  bus_rdata = DATA_W'(mask_q);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int DATA_W = 32,
  parameter int N_TMR  = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         irq_out,
  input logic [3*N_TMR:0]             ctrl_q,
  input logic [3*N_TMR-1:0]           st_q,
  input logic [3*N_TMR-1:0]           st_clr,
  input logic [N_TMR-1:0][DATA_W-1:0] cnt_q,
  input logic [N_TMR-1:0]             cnt_wr,
  input logic [N_TMR-1:0]             tick,
  input logic                         ext_rise
);
  localparam int UP_BIT = 3 * N_TMR;

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (st_q != '0)); // R9
  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise); // R10

  for (genvar i = 0; i < 3 * N_TMR; i++) begin : g_bit
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !st_clr[i]) |=> st_q[i]); // R8
  end

  for (genvar n = 0; n < N_TMR; n++) begin : g_ch
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[n] && !cnt_wr[n] && !ctrl_q[UP_BIT] && cnt_q[n] != '0)
      |=> cnt_q[n] == $past(cnt_q[n]) - 1'b1); // R3
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[3*n] && !cnt_wr[n]) |=> $stable(cnt_q[n])); // R7
    AST_NO_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q[3*n+2] && !ctrl_q[3*n+2]) |=> !st_q[3*n+2]); // R6
  end
endmodule

bind tt_top tt_checker #(.DATA_W(DATA_W), .N_TMR(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .ctrl_q(ctrl_q), .st_q(st_q),
  .st_clr(st_clr), .cnt_q(cnt_q), .cnt_wr(cnt_wr), .tick(tick), .ext_rise(ext_rise)
);

// File: tb/tt_top_bench.sv
module tt_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 15;

  localparam logic [5:0] V_ADDR [N_VEC] = '{
    6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C,
    6'h20, 6'h24, 6'h28, 6'h2C, 6'h30, 6'h38, 6'h3C};
  localparam logic [31:0] V_DATA [N_VEC] = '{
    32'h1234_5678, 32'hA5A5_0001, 32'h0F0F_F0F0, 32'hFFFF_FFFF,
    32'h8000_0000, 32'h0000_0001, 32'hDEAD_BEEF, 32'h7654_3210,
    32'h5555_AAAA, 32'hCAFE_F00D, 32'h0000_FFFF, 32'h1357_9BDF,
    32'hFFFF_FFB6, 32'hFFFF_FE5A, 32'hFFFF_FFFF};
  localparam logic [31:0] V_KEEP [N_VEC] = '{
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h0000_03FF, 32'h0000_01FF, 32'h0000_0000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_clk = 1'b0;
  logic        irq_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_top u_tt_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rdr(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); ext_clk = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: every register zero after reset, no interrupt
    for (int a = 0; a < 16; a++) begin
      rdr(6'(a * 4), rd);
      chk("R1 reg", rd, 32'h0);
    end
    chk("R1 irq", {31'd0, irq_out}, 32'd0);

    // R2: table of write/readback vectors, all channels off
    for (int i = 0; i < N_VEC; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rdr(V_ADDR[i], rd);
      chk("R2 map", rd, V_DATA[i] & V_KEEP[i]);
    end
    wr(6'h30, 32'h0);
    wr(6'h38, 32'h0);
    wr(6'h34, 32'h1FF);

    // R3/R5: channel 0 counting down, wrap flag enabled
    wr(6'h00, 32'd5); wr(6'h04, 32'd3); wr(6'h08, 32'd4); wr(6'h0C, 32'd10);
    wr(6'h30, 32'h5);
    repeat (7) @(posedge clk);
    wr(6'h30, 32'h0);
    rdr(6'h00, rd); chk("R3 down count and reload", rd, 32'd1);
    rdr(6'h34, rd); chk("R5 compare A plus wrap flag", rd, 32'h5);
    repeat (5) @(posedge clk);
    rdr(6'h00, rd); chk("R7 off channel holds", rd, 32'd1);
    rdr(6'h34, rd); chk("R7 no events while off", rd, 32'h5);

    // R8/R9: write-one-to-clear and masking
    chk("R9 irq raised", {31'd0, irq_out}, 32'd1);
    wr(6'h34, 32'h1);
    rdr(6'h34, rd); chk("R8 clear only written bit", rd, 32'h4);
    chk("R9 irq still up", {31'd0, irq_out}, 32'd1);
    wr(6'h38, 32'h4);
    rdr(6'h34, rd); chk("R9 masked irq", {31'd0, irq_out}, 32'd0);
    wr(6'h34, 32'h4);
    rdr(6'h34, rd); chk("R8 cleared", rd, 32'h0);
    wr(6'h38, 32'h0);

    // R4: channel 1 counting up through all ones
    wr(6'h10, 32'hFFFF_FFFD); wr(6'h14, 32'h10); wr(6'h18, 32'h10); wr(6'h1C, 32'h5);
    wr(6'h30, 32'h228);
    repeat (3) @(posedge clk);
    wr(6'h30, 32'h0);
    rdr(6'h10, rd); chk("R4 up wrap to reload", rd, 32'h11);
    rdr(6'h34, rd); chk("R4 R5 wrap and compare A on reload", rd, 32'h28);
    wr(6'h34, 32'h1FF);

    // R6: channel 2 wraps with its flag disabled
    wr(6'h20, 32'd1); wr(6'h24, 32'd7); wr(6'h28, 32'h100); wr(6'h2C, 32'h100);
    wr(6'h30, 32'h40);
    repeat (2) @(posedge clk);
    wr(6'h30, 32'h0);
    rdr(6'h20, rd); chk("R6 reload happened", rd, 32'd6);
    rdr(6'h34, rd); chk("R6 no wrap flag", rd, 32'h0);
    chk("R6 no irq", {31'd0, irq_out}, 32'd0);

    // R11: counter write wins over a tick
    wr(6'h20, 32'd50);
    wr(6'h30, 32'h40);
    wr(6'h20, 32'd20);
    wr(6'h30, 32'h0);
    rdr(6'h20, rd); chk("R11 write beats tick", rd, 32'd19);

    // R10: channel 0 on the external source
    wr(6'h00, 32'd10); wr(6'h08, 32'd9); wr(6'h0C, 32'h100);
    wr(6'h30, 32'h3);
    repeat (6) @(posedge clk);
    rdr(6'h00, rd); chk("R10 steady input no count", rd, 32'd10);
    ext_pulse();
    rdr(6'h00, rd); chk("R10 one count per edge", rd, 32'd9);
    rdr(6'h34, rd); chk("R10 R5 compare via external tick", rd, 32'h1);
    ext_pulse();
    rdr(6'h00, rd); chk("R10 second edge", rd, 32'd8);
    wr(6'h30, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule